// File: doc/BRIEF.md
# Oversampling UART Receiver with Two-Entry Character Queue

This block is the receive half of an asynchronous serial port. It watches the incoming serial line, synchronises it to the core clock and samples it on an external oversampling strobe. That strobe runs at 16 times the bit rate, and the receiver takes 8 strobes per bit when the double-speed control is set. A start bit is found on a falling edge and confirmed at its middle. Every later bit is decided by a two-out-of-three vote over the strobes around the bit centre.

A finished character is pushed into a two-deep queue together with its status bits: ninth data bit, parity error, framing error and overrun marker. The character count is selectable, and parity can be off, even or odd. Software reads the oldest entry at the head of the queue and pops it with a one-cycle strobe. A data-available flag stays high while the queue holds anything.

In a low-power state, a low level on the line raises a sticky wake flag. Both the wake flag and the data-available flag feed one combined interrupt line through their own enables. The strobe generator and the register interface sit outside this block.

Top module: `serial_rx_top`

## Requirements
- R1: After reset, `rxc_o`, `wake_o` and `irq_o` are 0.
- R2: A frame is an idle-high line, a low start bit, data bits least-significant first, an optional parity bit and a high stop bit. A correct 8-bit frame without parity places its byte at `rd_data_o`, with all status bits 0, and drives `rxc_o` to 1.
- R3: The data length follows `size_sel_i` (0, 1, 2, 3 give 5, 6, 7, 8 bits), or is 9 bits when `ninth_en_i` is 1. In a 9-bit frame the last received bit appears on `rd_bit8_o`. Data bits that the frame does not carry read as 0.
- R4: `par_mode_i` 2 selects even parity and 3 selects odd parity; 0 and 1 mean no parity bit. A parity bit that does not match the received data bits sets `rd_perr_o` for that entry.
- R5: A stop bit sampled low sets `rd_ferr_o` for that entry. The character is still stored. Only the first stop bit is examined.
- R6: The queue returns characters oldest first. A pulse on `rd_pop_i` removes the head entry, and `rxc_o` falls only when the last entry is popped.
- R7: A frame that completes while both entries are occupied is discarded. The newest stored entry gets `rd_ovr_o` set, and the older entry is unchanged.
- R8: With `dbl_speed_i` at 1, a bit lasts 8 sampling strobes instead of 16, and frames at that rate are received correctly.
- R9: A low pulse shorter than half a bit, followed by idle, yields no character.
- R10: A disturbance covering a single sampling strobe near a bit centre does not change the received bit.
- R11: While `stop_mode_i` is 1, a low line sets `wake_o`, which holds until `wake_clr_i` is pulsed. Outside stop mode a low line does not set it.
- R12: `irq_o` is 1 exactly when (`rxc_o` and `rxc_ie_i`) or (`wake_o` and `wake_ie_i`).
- R13: While `rx_en_i` is 0, no character enters the queue.
- R14: A pop with an empty queue has no effect: the next character received becomes the head and a single pop empties the queue again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rxd_i | input | 1 | Asynchronous serial input line |
| sample_tick_i | input | 1 | One-cycle oversampling strobe (16 per bit, 8 in double speed) |
| rx_en_i | input | 1 | Receiver enable |
| dbl_speed_i | input | 1 | Use 8 strobes per bit |
| size_sel_i | input | 2 | Data length 5..8 bits |
| ninth_en_i | input | 1 | 9-bit characters |
| par_mode_i | input | 2 | Parity: 0/1 none, 2 even, 3 odd |
| rd_pop_i | input | 1 | Remove head entry |
| stop_mode_i | input | 1 | Low-power state, arms the wake detector |
| wake_clr_i | input | 1 | Clear the wake flag |
| rxc_ie_i | input | 1 | Interrupt enable for data available |
| wake_ie_i | input | 1 | Interrupt enable for wake |
| rd_data_o | output | 8 | Head entry data byte |
| rd_bit8_o | output | 1 | Head entry ninth bit |
| rd_perr_o | output | 1 | Head entry parity error |
| rd_ferr_o | output | 1 | Head entry framing error |
| rd_ovr_o | output | 1 | Head entry overrun marker |
| rxc_o | output | 1 | Queue not empty |
| wake_o | output | 1 | Wake flag |
| irq_o | output | 1 | Combined interrupt |

## Verification
The bench aims at the queue edges. It sends three back-to-back characters, and a design that overwrote the head or the tail on overrun, or forgot to mark the survivor, returns a wrong byte or a clear `rd_ovr_o`. It pops an empty queue before a reception, and a counter that wrapped would leave `rxc_o` high after the later pop. It injects a one-strobe glitch at a bit centre and a short low pulse on an idle line; single-sample decisions would flip the bit, and a start detector without mid-bit confirmation would store a phantom character. Short and 9-bit frames, bad parity, a low stop bit and double-speed timing expose a bit counter or parity sense that is off by one or inverted.

// File: rtl/serial_rx_pkg.sv
`timescale 1ns/1ps
// Shared types for the serial receiver: queue entry layout and framer phases.
package serial_rx_pkg;

    localparam int DATA_W = 8;
    localparam int CHAR_MAX = DATA_W + 1;

    // One stored character with its status bits.
    typedef struct packed {
        logic [DATA_W-1:0] data;
        logic              bit8;
        logic              perr;
        logic              ferr;
        logic              ovr;
    } rx_entry_t;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START,
        PH_DATA,
        PH_PARITY,
        PH_STOP
    } rx_phase_e;

endpackage

// File: rtl/serial_rx_framer.sv
`timescale 1ns/1ps
// Frame recovery: detects a start edge, votes each bit from three strobes
// around its centre, collects data and parity, checks the first stop bit and
// emits a one-cycle push with the completed entry.
// Assumes rxd_i is already synchronised and tick_i is a one-cycle strobe.
module serial_rx_framer
    import serial_rx_pkg::*;
#(
    parameter int OSR_NORMAL = 16,
    parameter int OSR_DOUBLE = 8
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en_i,
    input  logic      tick_i,
    input  logic      rxd_i,
    input  logic      dbl_i,
    input  logic [1:0] size_sel_i,
    input  logic      ninth_en_i,
    input  logic [1:0] par_mode_i,
    output logic      push_o,
    output rx_entry_t entry_o
);

    localparam int CNT_W = $clog2(OSR_NORMAL);
    localparam int IDX_W = $clog2(CHAR_MAX);

    rx_phase_e           phase;
    logic [CNT_W-1:0]    cnt;
    logic [CNT_W-1:0]    cnt_n;
    logic [CNT_W-1:0]    last_pt;
    logic [CNT_W-1:0]    vote_pt;
    logic [IDX_W-1:0]    bit_idx;
    logic [IDX_W-1:0]    last_bit;
    logic [1:0]          win;
    logic                prev;
    logic [CHAR_MAX-1:0] shreg;
    logic                par_acc;
    logic                perr_q;
    logic                vote;
    logic                at_vote;
    logic                at_wrap;

    // Per-bit sample positions for the selected rate and the index of the final data bit.
    always_comb begin
        last_pt  = dbl_i ? CNT_W'(OSR_DOUBLE - 1) : CNT_W'(OSR_NORMAL - 1);
        vote_pt  = dbl_i ? CNT_W'(OSR_DOUBLE / 2 + 1) : CNT_W'(OSR_NORMAL / 2 + 1);
        last_bit = ninth_en_i ? IDX_W'(CHAR_MAX - 1) : IDX_W'(size_sel_i) + IDX_W'(4);
        cnt_n    = (cnt == last_pt) ? '0 : cnt + 1'b1;
        at_vote  = (cnt_n == vote_pt);
        at_wrap  = (cnt == last_pt);
        vote     = (win[1] & win[0]) | (win[1] & rxd_i) | (win[0] & rxd_i);
    end

    // Frame sequencer: advances one step per strobe and issues the push.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase   <= PH_IDLE;
            cnt     <= '0;
            bit_idx <= '0;
            win     <= 2'b11;
            prev    <= 1'b1;
            shreg   <= '0;
            par_acc <= 1'b0;
            perr_q  <= 1'b0;
            push_o  <= 1'b0;
            entry_o <= '0;
        end else begin
            push_o <= 1'b0;
            if (!en_i) begin
                phase <= PH_IDLE;
                prev  <= 1'b1;
            end else if (tick_i) begin
                win  <= {win[0], rxd_i};
                prev <= rxd_i;
                if (phase != PH_IDLE) begin
                    cnt <= cnt_n;
                end
                case (phase)
                    PH_IDLE: begin
                        if (prev && !rxd_i) begin
                            phase   <= PH_START;
                            cnt     <= '0;
                            shreg   <= '0;
                            par_acc <= 1'b0;
                            perr_q  <= 1'b0;
                        end
                    end
                    PH_START: begin
                        if (at_vote && vote) begin
                            phase <= PH_IDLE;
                        end else if (at_wrap) begin
                            phase   <= PH_DATA;
                            bit_idx <= '0;
                        end
                    end
                    PH_DATA: begin
                        if (at_vote) begin
                            for (int i = 0; i < CHAR_MAX; i++) begin
                                if (bit_idx == IDX_W'(i)) begin
                                    shreg[i] <= vote;
                                end
                            end
                            par_acc <= par_acc ^ vote;
                        end
                        if (at_wrap) begin
                            if (bit_idx == last_bit) begin
                                phase <= par_mode_i[1] ? PH_PARITY : PH_STOP;
                            end else begin
                                bit_idx <= bit_idx + 1'b1;
                            end
                        end
                    end
                    PH_PARITY: begin
                        if (at_vote) begin
                            perr_q <= par_acc ^ vote ^ par_mode_i[0];
                        end
                        if (at_wrap) begin
                            phase <= PH_STOP;
                        end
                    end
                    PH_STOP: begin
                        if (at_vote) begin
                            push_o        <= 1'b1;
                            entry_o.data  <= shreg[DATA_W-1:0];
                            entry_o.bit8  <= shreg[CHAR_MAX-1];
                            entry_o.perr  <= perr_q;
                            entry_o.ferr  <= ~vote;
                            entry_o.ovr   <= 1'b0;
                            phase         <= PH_IDLE;
                        end
                    end
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

endmodule

// File: rtl/serial_rx_queue.sv
`timescale 1ns/1ps
// Shifting character queue: head is always slot 0, new entries land behind
// the occupied slots. A push into a full queue is dropped and marks the
// newest stored entry. Assumes push and pop are one-cycle strobes.
module serial_rx_queue
    import serial_rx_pkg::*;
#(
    parameter int DEPTH = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      push_i,
    input  rx_entry_t din_i,
    input  logic      pop_i,
    output rx_entry_t head_o,
    output logic      not_empty_o
);

    localparam int CW = $clog2(DEPTH + 1);

    rx_entry_t        mem   [DEPTH];
    rx_entry_t        mem_n [DEPTH];
    logic [CW-1:0]    count;
    logic [CW-1:0]    count_n;

    // Next queue contents: pop first, then place or drop the incoming entry.
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            mem_n[i] = mem[i];
        end
        count_n = count;
        if (pop_i && (count != '0)) begin
            for (int i = 0; i < DEPTH - 1; i++) begin
                mem_n[i] = mem[i+1];
            end
            mem_n[DEPTH-1] = '0;
            count_n = count - 1'b1;
        end
        if (push_i) begin
            if (count_n < CW'(DEPTH)) begin
                for (int i = 0; i < DEPTH; i++) begin
                    if (count_n == CW'(i)) begin
                        mem_n[i] = din_i;
                    end
                end
                count_n = count_n + 1'b1;
            end else begin
                mem_n[DEPTH-1].ovr = 1'b1;
            end
        end
    end

    // Storage and occupancy registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= '0;
            end
            count <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= mem_n[i];
            end
            count <= count_n;
        end
    end

    assign head_o      = mem[0];
    assign not_empty_o = (count != '0);

endmodule

// File: rtl/serial_rx_wake.sv
`timescale 1ns/1ps
// Line-low wake detector: a sticky flag set by a low line while the
// low-power state is active, cleared by a strobe. Set wins over clear.
module serial_rx_wake (
    input  logic clk,
    input  logic rst_n,
    input  logic rxd_i,
    input  logic stop_mode_i,
    input  logic clr_i,
    output logic wake_o
);

    // Sticky wake flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wake_o <= 1'b0;
        end else begin
            wake_o <= (wake_o & ~clr_i) | (stop_mode_i & ~rxd_i);
        end
    end

endmodule

// File: rtl/serial_rx_top.sv
`timescale 1ns/1ps
// Serial receiver top: input synchroniser, frame recovery, two-entry
// character queue, wake detector and interrupt combine.
// Assumes sample_tick_i comes from an external strobe generator.
module serial_rx_top
    import serial_rx_pkg::*;
#(
    parameter int OSR_NORMAL  = 16,
    parameter int OSR_DOUBLE  = 8,
    parameter int QDEPTH      = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rxd_i,
    input  logic       sample_tick_i,
    input  logic       rx_en_i,
    input  logic       dbl_speed_i,
    input  logic [1:0] size_sel_i,
    input  logic       ninth_en_i,
    input  logic [1:0] par_mode_i,
    input  logic       rd_pop_i,
    input  logic       stop_mode_i,
    input  logic       wake_clr_i,
    input  logic       rxc_ie_i,
    input  logic       wake_ie_i,
    output logic [7:0] rd_data_o,
    output logic       rd_bit8_o,
    output logic       rd_perr_o,
    output logic       rd_ferr_o,
    output logic       rd_ovr_o,
    output logic       rxc_o,
    output logic       wake_o,
    output logic       irq_o
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   rxd_s;
    logic                   frm_push;
    rx_entry_t              frm_entry;
    rx_entry_t              head;

    // Metastability chain on the asynchronous line, idles high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= '1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], rxd_i};
        end
    end
    assign rxd_s = sync_q[SYNC_STAGES-1];

    serial_rx_framer #(
        .OSR_NORMAL (OSR_NORMAL),
        .OSR_DOUBLE (OSR_DOUBLE)
    ) u_framer (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_i       (rx_en_i),
        .tick_i     (sample_tick_i),
        .rxd_i      (rxd_s),
        .dbl_i      (dbl_speed_i),
        .size_sel_i (size_sel_i),
        .ninth_en_i (ninth_en_i),
        .par_mode_i (par_mode_i),
        .push_o     (frm_push),
        .entry_o    (frm_entry)
    );

    serial_rx_queue #(
        .DEPTH (QDEPTH)
    ) u_queue (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (frm_push),
        .din_i       (frm_entry),
        .pop_i       (rd_pop_i),
        .head_o      (head),
        .not_empty_o (rxc_o)
    );

    serial_rx_wake u_wake (
        .clk         (clk),
        .rst_n       (rst_n),
        .rxd_i       (rxd_s),
        .stop_mode_i (stop_mode_i),
        .clr_i       (wake_clr_i),
        .wake_o      (wake_o)
    );

    assign rd_data_o = head.data;
    assign rd_bit8_o = head.bit8;
    assign rd_perr_o = head.perr;
    assign rd_ferr_o = head.ferr;
    assign rd_ovr_o  = head.ovr;
    assign irq_o     = (rxc_o & rxc_ie_i) | (wake_o & wake_ie_i);

endmodule

// File: rtl/serial_rx_chk.sv
`timescale 1ns/1ps
// Protocol checker for serial_rx_top, attached by bind below.
module serial_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_en_i,
    input logic       rd_pop_i,
    input logic       stop_mode_i,
    input logic       wake_clr_i,
    input logic       frm_push,
    input logic       rxc_o,
    input logic [7:0] rd_data_o,
    input logic       wake_o
);

    AST_HEAD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        rxc_o && !rd_pop_i |=> rxc_o && $stable(rd_data_o)); // R6

    AST_RXC_FALL_POP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rxc_o) |-> $past(rd_pop_i)); // R6

    AST_EMPTY_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        !rxc_o && !frm_push |=> !rxc_o); // R14

    AST_NO_PUSH_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rx_en_i) |-> !frm_push); // R13

    AST_WAKE_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_mode_i && !wake_o |=> !wake_o); // R11

    AST_WAKE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        wake_clr_i && !stop_mode_i |=> !wake_o); // R11

endmodule

bind serial_rx_top serial_rx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rx_en_i     (rx_en_i),
    .rd_pop_i    (rd_pop_i),
    .stop_mode_i (stop_mode_i),
    .wake_clr_i  (wake_clr_i),
    .frm_push    (frm_push),
    .rxc_o       (rxc_o),
    .rd_data_o   (rd_data_o),
    .wake_o      (wake_o)
);

// File: tb/sim_serial_rx_top.sv
`timescale 1ns/1ps
module sim_serial_rx_top;

    localparam int TD = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rxd = 1'b1;
    logic       tick = 1'b0;
    logic       rx_en = 1'b1;
    logic       dbl = 1'b0;
    logic [1:0] size_sel = 2'd3;
    logic       ninth = 1'b0;
    logic [1:0] pmode = 2'd0;
    logic       pop = 1'b0;
    logic       stop_mode = 1'b0;
    logic       wclr = 1'b0;
    logic       rxc_ie = 1'b0;
    logic       wake_ie = 1'b0;
    logic [7:0] rd_data;
    logic       rd_bit8, rd_perr, rd_ferr, rd_ovr, rxc, wake, irq;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    serial_rx_top u0 (
        .clk(clk), .rst_n(rst_n), .rxd_i(rxd), .sample_tick_i(tick),
        .rx_en_i(rx_en), .dbl_speed_i(dbl), .size_sel_i(size_sel),
        .ninth_en_i(ninth), .par_mode_i(pmode), .rd_pop_i(pop),
        .stop_mode_i(stop_mode), .wake_clr_i(wclr), .rxc_ie_i(rxc_ie),
        .wake_ie_i(wake_ie), .rd_data_o(rd_data), .rd_bit8_o(rd_bit8),
        .rd_perr_o(rd_perr), .rd_ferr_o(rd_ferr), .rd_ovr_o(rd_ovr),
        .rxc_o(rxc), .wake_o(wake), .irq_o(irq)
    );

    // Oversampling strobe: one cycle high every TD cycles.
    initial begin
        forever begin
            @(negedge clk) tick = 1'b1;
            @(negedge clk) tick = 1'b0;
            repeat (TD - 2) @(negedge clk);
        end
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_errors++;
        $display("FAIL watchdog: act=timeout exp=completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    function automatic int osr();
        return dbl ? 8 : 16;
    endfunction

    task automatic hold(input logic v, input int clocks);
        rxd = v;
        repeat (clocks) @(negedge clk);
    endtask

    // Drive one frame with the current configuration; glitch_bit >= 0 flips
    // that data bit for one strobe period around its centre.
    task automatic send_frame(input logic [8:0] d, input bit bad_par,
                              input bit bad_stop, input int glitch_bit);
        int nb = ninth ? 9 : 5 + int'(size_sel);
        int bt = osr() * TD;
        logic p = 1'b0;
        @(negedge clk);
        hold(1'b0, bt);
        for (int i = 0; i < nb; i++) begin
            p ^= d[i];
            if (i == glitch_bit) begin
                hold(d[i], bt / 2 - TD / 2);
                hold(~d[i], TD);
                hold(d[i], bt - bt / 2 - TD / 2);
            end else begin
                hold(d[i], bt);
            end
        end
        if (pmode[1]) hold(p ^ pmode[0] ^ bad_par, bt);
        if (bad_stop) begin
            hold(1'b0, bt);
            hold(1'b1, bt);
        end else begin
            hold(1'b1, bt);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic do_pop();
        @(negedge clk) pop = 1'b1;
        @(negedge clk) pop = 1'b0;
        @(negedge clk);
    endtask

    task automatic expect_head(input string req, input logic [7:0] d, input logic b8,
                               input logic pe, input logic fe, input logic ov);
        check(req, {19'd0, rxc, rd_data, rd_bit8, rd_perr, rd_ferr, rd_ovr},
                   {19'd0, 1'b1, d, b8, pe, fe, ov});
    endtask

    task automatic t_reset();
        check("R1 rxc", rxc, 0);
        check("R1 wake", wake, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_basic();
        send_frame(9'h0A5, 0, 0, -1);
        expect_head("R2 8N1", 8'hA5, 0, 0, 0, 0);
        do_pop();
        check("R6 empty after pop", rxc, 0);
    endtask

    task automatic t_sizes();
        size_sel = 2'd0;
        send_frame(9'h0F5, 0, 0, -1);
        expect_head("R3 5-bit", 8'h15, 0, 0, 0, 0);
        do_pop();
        size_sel = 2'd2;
        send_frame(9'h0DA, 0, 0, -1);
        expect_head("R3 7-bit", 8'h5A, 0, 0, 0, 0);
        do_pop();
        size_sel = 2'd3;
        ninth = 1'b1;
        send_frame(9'h1C3, 0, 0, -1);
        expect_head("R3 9-bit", 8'hC3, 1, 0, 0, 0);
        do_pop();
        ninth = 1'b0;
    endtask

    task automatic t_parity();
        pmode = 2'd2;
        send_frame(9'h0B7, 0, 0, -1);
        expect_head("R4 even ok", 8'hB7, 0, 0, 0, 0);
        do_pop();
        pmode = 2'd3;
        send_frame(9'h0B7, 0, 0, -1);
        expect_head("R4 odd ok", 8'hB7, 0, 0, 0, 0);
        do_pop();
        pmode = 2'd2;
        send_frame(9'h03C, 1, 0, -1);
        expect_head("R4 even bad", 8'h3C, 0, 1, 0, 0);
        do_pop();
        pmode = 2'd0;
    endtask

    task automatic t_ferr();
        send_frame(9'h066, 0, 1, -1);
        expect_head("R5 frame err", 8'h66, 0, 0, 1, 0);
        do_pop();
    endtask

    task automatic t_order_overrun();
        send_frame(9'h011, 0, 0, -1);
        send_frame(9'h022, 0, 0, -1);
        expect_head("R6 oldest first", 8'h11, 0, 0, 0, 0);
        send_frame(9'h033, 0, 0, -1);
        expect_head("R7 head kept", 8'h11, 0, 0, 0, 0);
        do_pop();
        check("R6 rxc after one pop", rxc, 1);
        expect_head("R7 tail marked", 8'h22, 0, 0, 0, 1);
        do_pop();
        check("R7 third dropped", rxc, 0);
    endtask

    task automatic t_double();
        dbl = 1'b1;
        send_frame(9'h0C9, 0, 0, -1);
        expect_head("R8 double speed", 8'hC9, 0, 0, 0, 0);
        do_pop();
        dbl = 1'b0;
    endtask

    task automatic t_false_start();
        @(negedge clk);
        hold(1'b0, 3 * TD);
        hold(1'b1, 12 * 16 * TD);
        check("R9 no phantom", rxc, 0);
    endtask

    task automatic t_glitch();
        send_frame(9'h0AA, 0, 0, 3);
        expect_head("R10 glitch voted out", 8'hAA, 0, 0, 0, 0);
        do_pop();
    endtask

    task automatic t_wake_irq();
        rx_en = 1'b0;
        wake_ie = 1'b1;
        @(negedge clk);
        hold(1'b0, 6);
        check("R11 no wake outside stop", wake, 0);
        stop_mode = 1'b1;
        repeat (5) @(negedge clk);
        check("R11 wake set", wake, 1);
        check("R12 wake irq", irq, 1);
        hold(1'b1, 4);
        check("R11 wake sticky", wake, 1);
        stop_mode = 1'b0;
        wclr = 1'b1;
        @(negedge clk) wclr = 1'b0;
        @(negedge clk);
        check("R11 wake cleared", wake, 0);
        check("R12 irq low", irq, 0);
        wake_ie = 1'b0;
        rx_en = 1'b1;
        repeat (4 * TD) @(negedge clk);
        send_frame(9'h05A, 0, 0, -1);
        check("R12 rxc masked", irq, 0);
        rxc_ie = 1'b1;
        @(negedge clk);
        check("R12 rxc irq", irq, 1);
        do_pop();
        check("R12 irq after pop", irq, 0);
        rxc_ie = 1'b0;
    endtask

    task automatic t_disabled();
        rx_en = 1'b0;
        send_frame(9'h081, 0, 0, -1);
        check("R13 disabled no char", rxc, 0);
        rx_en = 1'b1;
        repeat (4 * TD) @(negedge clk);
    endtask

    task automatic t_empty_pop();
        do_pop();
        check("R14 still empty", rxc, 0);
        send_frame(9'h03C, 0, 0, -1);
        expect_head("R14 head after empty pop", 8'h3C, 0, 0, 0, 0);
        do_pop();
        check("R14 single pop empties", rxc, 0);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        repeat (4 * TD) @(negedge clk);
        t_basic();
        t_sizes();
        t_parity();
        t_ferr();
        t_order_overrun();
        t_double();
        t_false_start();
        t_glitch();
        t_wake_irq();
        t_disabled();
        t_empty_pop();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule